// File: doc/BRIEF.md
# Round Subkey Generator with On-the-Fly Constants

This block feeds a 64-bit lightweight block-cipher core with its round subkeys. After a 128-bit master key is loaded, each advance pulse produces the four subkey bytes for the next of 32 rounds. Over a full run it produces 128 subkeys. Each subkey is one master-key byte added modulo 256 to a round constant.

The constants are not read from a stored table. A 7-bit linear feedback register steps four times per round. Its four successive states give the four constants for that round. One load always starts the sequence from the same seed. The core then issues one advance per round and reads the subkeys and the round number from the outputs. Once 32 rounds have been produced, further advances are ignored until the next load.

Top module: `hight_sk_gen`

## Requirements
- R1: After reset, `sk_o` is all zero and `round_o` is 0. Reset also acts as a load of an all-zero key.
- R2: A cycle with `load_i` high captures `key_i`, clears `sk_o` to zero and `round_o` to 0, and restarts the constant sequence from the seed. This is visible in the cycle after the load.
- R3: Each accepted advance updates the outputs in the next cycle. `round_o` then shows the round whose subkeys are on `sk_o`, counting 0, 1, …, 31 in order after each load.
- R4: Constant c is the 7-bit state s6..s0 with a zero bit 7. The state starts at 0x5A, and each step gives the next state {s3 xor s0, s6..s1}. Constants 4r to 4r+3 belong to round r, in lane order 0 to 3.
- R5: Master-key byte n is `key_i[8n+7:8n]`. Lane m (`sk_o[8m+7:8m]`) of round r holds subkey k=4r+m. Write i=k/16, j=k mod 8 and u=(j-i) mod 8. If bit 3 of k is 0, the subkey uses key byte u; otherwise it uses key byte u+8.
- R6: The key byte and the constant are added modulo 256, and any carry out of bit 7 is dropped.
- R7: Exactly 32 advances are accepted after each load. Advances after the 32nd leave `sk_o` and `round_o` unchanged.
- R8: When `load_i` and `advance_i` are high in the same cycle, the load wins, and the advance has no effect.
- R9: In a cycle with neither `load_i` nor `advance_i`, `sk_o` and `round_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture key and restart the schedule |
| key_i | input | 128 | Master key, byte n at bits 8n+7..8n |
| advance_i | input | 1 | Produce the next round's subkeys |
| sk_o | output | 32 | Four subkey bytes, lane m at bits 8m+7..8m |
| round_o | output | 5 | Round number of the subkeys on `sk_o` |

## Verification
On every cycle, the assertions check the control behaviour:
- clearing after a load;
- holding when idle;
- holding once the 32 rounds are used up;
- rounds following the accepted-advance count;
- the counter staying within its bound.

The subkey values themselves, meaning the constant sequence, the byte rotation between rounds and the modulo-256 wrap, can only be shown by the bench. It sweeps all 32 rounds under several keys against a model built from the requirements. The bench also drives load and advance together in the middle of a run.

// File: rtl/hight_sk_pkg.sv
package hight_sk_pkg;
  localparam int unsigned LFSR_W = 7;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 7'h5A;

  // s(i+7) = s(i+3) ^ s(i), state shifts toward bit 0
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[3] ^ s[0], s[LFSR_W-1:1]};
  endfunction
endpackage

// File: rtl/hight_delta_lfsr.sv
module hight_delta_lfsr
  import hight_sk_pkg::*;
#(
  parameter int unsigned STEPS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 restart_i,
  input  logic                 step_i,
  output logic [STEPS*8-1:0]   delta_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] chain [STEPS+1];

  assign chain[0] = state_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_stage
    assign chain[g+1] = lfsr_next(chain[g]);
    assign delta_o[8*g +: 8] = {{(8-LFSR_W){1'b0}}, chain[g]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= LFSR_SEED;
    else if (restart_i) state_q <= LFSR_SEED;
    else if (step_i)    state_q <= chain[STEPS];
  end
endmodule

// File: rtl/hight_sk_lane.sv
module hight_sk_lane #(
  parameter int unsigned NUM_ROUNDS   = 32,
  parameter int unsigned SK_PER_ROUND = 4,
  parameter int unsigned LANE         = 0
) (
  input  logic [127:0]                    key_i,
  input  logic [$clog2(NUM_ROUNDS)-1:0]   round_i,
  input  logic [7:0]                      delta_i,
  output logic [7:0]                      sk_o
);
  localparam int unsigned K_W = $clog2(NUM_ROUNDS * SK_PER_ROUND);
  localparam logic [K_W-1:0] LANE_K = K_W'(LANE);
  localparam logic [K_W-1:0] SPR_K  = K_W'(SK_PER_ROUND);

  logic [K_W-1:0] k;
  logic [2:0]     rot;
  logic [3:0]     byte_sel;

  assign k        = K_W'(round_i) * SPR_K + LANE_K;
  // rotate within each 8-byte half by the 16-subkey group number
  assign rot      = k[2:0] - k[K_W-1:4];
  assign byte_sel = {k[3], rot};
  assign sk_o     = key_i[8*byte_sel +: 8] + delta_i;
endmodule

// File: rtl/hight_sk_gen.sv
module hight_sk_gen #(
  parameter int unsigned NUM_ROUNDS   = 32,
  parameter int unsigned SK_PER_ROUND = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [127:0]                  key_i,
  input  logic                          advance_i,
  output logic [SK_PER_ROUND*8-1:0]     sk_o,
  output logic [$clog2(NUM_ROUNDS)-1:0] round_o
);
  localparam int unsigned RND_W = $clog2(NUM_ROUNDS);
  localparam int unsigned CNT_W = $clog2(NUM_ROUNDS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_ROUNDS);

  logic [127:0]                key_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [SK_PER_ROUND*8-1:0]   sk_q, sk_d, delta;
  logic [RND_W-1:0]            round_q;
  logic                        accept;

  assign accept = advance_i && !load_i && (cnt_q < CNT_MAX);

  hight_delta_lfsr #(.STEPS(SK_PER_ROUND)) u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_i),
    .step_i    (accept),
    .delta_o   (delta)
  );

  for (genvar m = 0; m < SK_PER_ROUND; m++) begin : g_lane
    hight_sk_lane #(
      .NUM_ROUNDS  (NUM_ROUNDS),
      .SK_PER_ROUND(SK_PER_ROUND),
      .LANE        (m)
    ) u_lane (
      .key_i   (key_q),
      .round_i (cnt_q[RND_W-1:0]),
      .delta_i (delta[8*m +: 8]),
      .sk_o    (sk_d[8*m +: 8])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      cnt_q   <= '0;
      sk_q    <= '0;
      round_q <= '0;
    end else if (load_i) begin
      key_q   <= key_i;
      cnt_q   <= '0;
      sk_q    <= '0;
      round_q <= '0;
    end else if (accept) begin
      cnt_q   <= cnt_q + 1'b1;
      sk_q    <= sk_d;
      round_q <= cnt_q[RND_W-1:0];
    end
  end

  assign sk_o    = sk_q;
  assign round_o = round_q;
endmodule

// File: rtl/hight_sk_gen_chk.sv
module hight_sk_gen_chk #(
  parameter int unsigned NUM_ROUNDS   = 32,
  parameter int unsigned SK_PER_ROUND = 4
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               load_i,
  input logic                               advance_i,
  input logic [SK_PER_ROUND*8-1:0]          sk_o,
  input logic [$clog2(NUM_ROUNDS)-1:0]      round_o,
  input logic [$clog2(NUM_ROUNDS+1)-1:0]    cnt_q
);
  localparam int unsigned CNT_W = $clog2(NUM_ROUNDS + 1);
  localparam int unsigned RND_W = $clog2(NUM_ROUNDS);

  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sk_o == '0 && round_o == '0 && cnt_q == '0)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !advance_i) |=> ($stable(sk_o) && $stable(round_o))); // R9

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && advance_i && cnt_q == CNT_W'(NUM_ROUNDS)) |=> ($stable(sk_o) && $stable(round_o))); // R7

  AST_ROUND_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && advance_i && cnt_q < CNT_W'(NUM_ROUNDS)) |=>
      (round_o == $past(cnt_q[RND_W-1:0]) && cnt_q == $past(cnt_q) + 1'b1)); // R3

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && advance_i) |=> (cnt_q == '0)); // R8

  always_comb begin
    if (rst_ni) AST_CNT_BOUND: assert (cnt_q <= CNT_W'(NUM_ROUNDS)); // R7
  end
endmodule

bind hight_sk_gen hight_sk_gen_chk #(
  .NUM_ROUNDS  (NUM_ROUNDS),
  .SK_PER_ROUND(SK_PER_ROUND)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .advance_i (advance_i),
  .sk_o      (sk_o),
  .round_o   (round_o),
  .cnt_q     (cnt_q)
);

// File: tb/hight_sk_gen_tb_top.sv
`timescale 1ns/1ps
module hight_sk_gen_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic         adv = 1'b0;
  logic [127:0] key = '0;
  logic [31:0]  sk;
  logic [4:0]   rnd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [6:0] delta_m [128];

  always #2.5 clk = ~clk;

  hight_sk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .key_i(key),
    .advance_i(adv), .sk_o(sk), .round_o(rnd)
  );

  function automatic logic [31:0] exp_sk(input logic [127:0] k, input int r);
    logic [31:0] v;
    for (int m = 0; m < 4; m++) begin
      int idx, i, j, u;
      idx = 4 * r + m;
      i = idx / 16;
      j = idx % 8;
      u = (j - i + 8) % 8;
      if ((idx % 16) >= 8) u = u + 8;
      v[8*m +: 8] = k[8*u +: 8] + {1'b0, delta_m[idx]};
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [127:0] k, input logic with_adv);
    @(negedge clk);
    key = k; load = 1'b1; adv = with_adv;
    @(negedge clk);
    load = 1'b0; adv = 1'b0;
  endtask

  task automatic do_adv();
    @(negedge clk);
    adv = 1'b1;
    @(negedge clk);
    adv = 1'b0;
  endtask

  task automatic sweep(input logic [127:0] k, input string req);
    for (int r = 0; r < 32; r++) begin
      do_adv();
      check(req, sk, exp_sk(k, r));
      check("R3", {27'd0, rnd}, r);
    end
  endtask

  logic [127:0] key_dist, key_ones;

  initial begin
    logic [6:0] s;
    s = 7'h5A;
    for (int n = 0; n < 128; n++) begin  // R4 model
      delta_m[n] = s;
      s = {s[3] ^ s[0], s[6:1]};
    end
    for (int n = 0; n < 16; n++) key_dist[8*n +: 8] = 8'(n * 17 + 3);
    key_ones = '1;

    repeat (3) @(negedge clk);
    check("R1", sk, 32'd0);
    check("R1", {27'd0, rnd}, 32'd0);
    rst_n = 1'b1;

    // R4: zero key exposes constants directly
    do_load('0, 1'b0);
    sweep('0, "R4");
    repeat (2) @(negedge clk);
    check("R9", sk, exp_sk('0, 31));
    for (int e = 0; e < 3; e++) begin
      do_adv();
      check("R7", sk, exp_sk('0, 31));
      check("R7", {27'd0, rnd}, 32'd31);
    end

    // R5: distinct bytes reveal the rotation, idle gap mid-run
    do_load(key_dist, 1'b0);
    check("R2", sk, 32'd0);
    check("R2", {27'd0, rnd}, 32'd0);
    for (int r = 0; r < 32; r++) begin
      do_adv();
      check("R5", sk, exp_sk(key_dist, r));
      check("R3", {27'd0, rnd}, r);
      if (r == 10) begin
        repeat (2) @(negedge clk);
        check("R9", sk, exp_sk(key_dist, 10));
        check("R9", {27'd0, rnd}, 32'd10);
      end
    end

    // R6: all-ones key forces wrap
    do_load(key_ones, 1'b0);
    sweep(key_ones, "R6");

    // R8: load with advance mid-run restarts at round 0
    do_load(key_dist, 1'b0);
    for (int r = 0; r < 5; r++) do_adv();
    do_load(key_ones, 1'b1);
    check("R8", sk, 32'd0);
    check("R8", {27'd0, rnd}, 32'd0);
    do_adv();
    check("R8", sk, exp_sk(key_ones, 0));
    check("R2", {27'd0, rnd}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule